// File: doc/BRIEF.md
# Integer Execute Unit with Flags and Branch Resolution

This block is the arithmetic part of a simple sequential processor's execute step. Each cycle it receives two operands, an instruction class code and a function code. For the integer-operation class it adds, subtracts, ANDs or XORs the operands, as the function code selects. When a set-flags enable is also high, it captures zero, sign and overflow flags into a register at the clock edge.

For the jump class, the function code instead names a condition. That condition is tested against the flags already held in the register, which gives a one-bit taken signal. A multiplexer then gives the next program counter: the jump target if the jump is taken, otherwise the fall-through address.

Operand values, the result and the next program counter are combinational in the current cycle. Only the flags are state.

Top module: `exec_unit`

## Requirements
- R1: With class code 6 (integer op) and function 0, `val_e` = `val_b` + `val_a`, modulo 2^W.
- R2: With class code 6 and function 1, `val_e` = `val_b` - `val_a`. For example, b=21 and a=9 gives 12, and all three flags clear.
- R3: With class code 6, function 2 gives `val_b & val_a` and function 3 gives `val_b ^ val_a`. Both clear the overflow flag.
- R4: Flags are written on the clock edge only when `set_cc_en` is 1, the class code is 6 and the function is 0..3. The flags are `flags_q[2]`=zero (result equal to 0), `flags_q[1]`=sign (MSB of result) and `flags_q[0]`=overflow. Overflow is signed overflow for add and subtract.
- R5: In every other cycle the flags keep their value. This covers other class codes, `set_cc_en` low, and undefined functions.
- R6: With class code 7 (jump), `cnd` is computed from the held flags, with lt = sign XOR overflow. The function codes are 0 always, 1 lt or zero, 2 lt, 3 zero, 4 not zero, 5 not lt, and 6 neither lt nor zero. Functions 7..15 give `cnd`=0.
- R7: `next_pc` = `val_c` when `cnd` is 1, else `val_p`.
- R8: For any class code other than 7, `cnd` is 0 and `next_pc` = `val_p`.
- R9: A synchronous active-high `rst` clears all three flags.
- R10: With class code 6 and a function of 4..15, `val_e` is 0 and the flags are not written.
- R11: For class codes other than 6, `val_e` = `val_b` + `val_a`, whatever the function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icode | input | 4 | Instruction class code |
| ifun | input | 4 | Function / condition code |
| val_a | input | W | First operand |
| val_b | input | W | Second operand |
| val_c | input | W | Jump target |
| val_p | input | W | Fall-through address |
| set_cc_en | input | 1 | Permit flag update |
| val_e | output | W | Execute result |
| flags_q | output | 3 | Held flags {zero, sign, overflow} |
| cnd | output | 1 | Jump taken |
| next_pc | output | W | Selected next program counter |

## Verification
Several properties are checked on every clock cycle:
- the flags hold steady whenever no write is permitted;
- a permitted write stores a zero flag and sign flag that match the previous cycle's result;
- logic operations leave overflow clear;
- non-jump classes always fall through;
- reset clears the flags.

Some behaviours can only be shown by the bench's instruction sequences. These are:
- the exact arithmetic of each operation, including the overflow boundaries at the most positive and most negative values;
- each of the seven jump conditions under flag patterns chosen to separate them;
- the undefined function codes.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int unsigned CODE_W = 4;

    localparam logic [CODE_W-1:0] CLS_INTOP = 4'd6;
    localparam logic [CODE_W-1:0] CLS_JUMP  = 4'd7;

    typedef enum logic [CODE_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef enum logic [CODE_W-1:0] {
        JC_ALWAYS = 4'd0,
        JC_LE     = 4'd1,
        JC_LT     = 4'd2,
        JC_EQ     = 4'd3,
        JC_NE     = 4'd4,
        JC_GE     = 4'd5,
        JC_GT     = 4'd6
    } jcond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b0, sf: 1'b0, of: 1'b0};

    function automatic logic lt_of(flags_t f);
        return f.sf ^ f.of;
    endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
    import exec_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [CODE_W-1:0] icode,
    input  logic [CODE_W-1:0] ifun,
    input  logic [W-1:0]      val_a,
    input  logic [W-1:0]      val_b,
    output logic [W-1:0]      val_e,
    output flags_t            flags_new,
    output logic              flags_ok
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] sum, diff;
    logic         ovf_add, ovf_sub, ovf;

    assign sum     = val_b + val_a;
    assign diff    = val_b - val_a;
    assign ovf_add = (val_a[MSB] == val_b[MSB]) && (sum[MSB] != val_b[MSB]);
    assign ovf_sub = (val_a[MSB] != val_b[MSB]) && (diff[MSB] != val_b[MSB]);

    always_comb begin
        val_e    = sum;
        ovf      = 1'b0;
        flags_ok = 1'b0;
        if (icode == CLS_INTOP) begin
            flags_ok = 1'b1;
            case (alu_fn_e'(ifun))
                FN_ADD: begin val_e = sum;           ovf = ovf_add; end
                FN_SUB: begin val_e = diff;          ovf = ovf_sub; end
                FN_AND: begin val_e = val_b & val_a; ovf = 1'b0;    end
                FN_XOR: begin val_e = val_b ^ val_a; ovf = 1'b0;    end
                default: begin
                    val_e    = '0;
                    flags_ok = 1'b0;
                end
            endcase
        end
    end

    assign flags_new = '{zf: (val_e == '0), sf: val_e[MSB], of: ovf};
endmodule

// File: rtl/cc_reg.sv
module cc_reg
    import exec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= FLAGS_RESET;
        else if (we)
            q <= d;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (q == FLAGS_RESET));
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import exec_pkg::*;
(
    input  logic              is_jump,
    input  logic [CODE_W-1:0] ifun,
    input  flags_t            flags,
    output logic              cnd
);
    logic lt;
    assign lt = lt_of(flags);

    always_comb begin
        cnd = 1'b0;
        if (is_jump) begin
            case (jcond_e'(ifun))
                JC_ALWAYS: cnd = 1'b1;
                JC_LE:     cnd = lt | flags.zf;
                JC_LT:     cnd = lt;
                JC_EQ:     cnd = flags.zf;
                JC_NE:     cnd = ~flags.zf;
                JC_GE:     cnd = ~lt;
                JC_GT:     cnd = ~lt & ~flags.zf;
                default:   cnd = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        icode,
    input  logic [3:0]        ifun,
    input  logic [W-1:0]      val_a,
    input  logic [W-1:0]      val_b,
    input  logic [W-1:0]      val_c,
    input  logic [W-1:0]      val_p,
    input  logic              set_cc_en,
    output logic [W-1:0]      val_e,
    output logic [2:0]        flags_q,
    output logic              cnd,
    output logic [W-1:0]      next_pc
);
    flags_t flags_new, flags_cur;
    logic   flags_ok, cc_we;

    alu_core #(.W(W)) u_alu (
        .icode     (icode),
        .ifun      (ifun),
        .val_a     (val_a),
        .val_b     (val_b),
        .val_e     (val_e),
        .flags_new (flags_new),
        .flags_ok  (flags_ok)
    );

    assign cc_we = set_cc_en & flags_ok;

    cc_reg u_cc (
        .clk (clk),
        .rst (rst),
        .we  (cc_we),
        .d   (flags_new),
        .q   (flags_cur)
    );

    branch_eval u_br (
        .is_jump (icode == CLS_JUMP),
        .ifun    (ifun),
        .flags   (flags_cur),
        .cnd     (cnd)
    );

    assign next_pc = cnd ? val_c : val_p;
    assign flags_q = flags_cur;

    assert_flag_capture_R4: assert property (@(posedge clk) disable iff (rst)
        cc_we |=> (flags_q[2] == ($past(val_e) == '0)) && (flags_q[1] == $past(val_e[W-1])));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (set_cc_en && icode == CLS_INTOP && (ifun == 4'd2 || ifun == 4'd3)) |=> !flags_q[0]);

    assert_fallthrough_R8: assert property (@(posedge clk) disable iff (rst)
        (icode != CLS_JUMP) |-> (!cnd && next_pc == val_p));
endmodule

// File: tb/tb_exec_unit.sv
module tb_exec_unit;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] e;
        logic         c;
        logic [W-1:0] npc;
        logic [2:0]   fl;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   icode = '0, ifun = '0;
    logic [W-1:0] val_a = '0, val_b = '0, val_c = '0, val_p = '0;
    logic         set_cc_en = 1'b0;
    logic [W-1:0] val_e, next_pc;
    logic [2:0]   flags_q;
    logic         cnd;

    int checks = 0, errors = 0;
    exp_t sb[$];
    logic [2:0] model_fl = 3'b000;
    bit done = 0;

    always #2 clk = ~clk;

    exec_unit #(.W(W)) dut (
        .clk(clk), .rst(rst), .icode(icode), .ifun(ifun),
        .val_a(val_a), .val_b(val_b), .val_c(val_c), .val_p(val_p),
        .set_cc_en(set_cc_en), .val_e(val_e), .flags_q(flags_q),
        .cnd(cnd), .next_pc(next_pc)
    );

    function automatic logic jump_taken(logic [3:0] f, logic [2:0] fl);
        logic z, n;
        z = fl[2];
        n = fl[1] ^ fl[0];
        if (f == 4'd0) return 1'b1;
        if (f == 4'd1) return n || z;
        if (f == 4'd2) return n;
        if (f == 4'd3) return z;
        if (f == 4'd4) return !z;
        if (f == 4'd5) return !n;
        if (f == 4'd6) return !n && !z;
        return 1'b0;
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(string req, logic [3:0] ic, logic [3:0] fn,
                         logic [W-1:0] a, logic [W-1:0] b, logic we);
        exp_t x;
        logic [W-1:0] r;
        logic ov, upd;
        @(negedge clk);
        icode = ic; ifun = fn; val_a = a; val_b = b; set_cc_en = we;
        val_c = 32'h0000_0400 + {24'd0, ic, fn}; val_p = 32'h0000_0100 + {28'd0, fn};
        upd = 1'b0; ov = 1'b0; r = b + a;
        if (ic == 4'd6) begin
            upd = we;
            case (fn)
                4'd0: begin r = b + a; ov = (a[31] == b[31]) && (r[31] != b[31]); end
                4'd1: begin r = b - a; ov = (a[31] != b[31]) && (r[31] != b[31]); end
                4'd2: r = b & a;
                4'd3: r = b ^ a;
                default: begin r = '0; upd = 1'b0; end
            endcase
        end
        x.e = r;
        x.c = (ic == 4'd7) ? jump_taken(fn, model_fl) : 1'b0;
        x.npc = x.c ? val_c : val_p;
        x.fl = model_fl;
        x.req = req;
        sb.push_back(x);
        if (upd) model_fl = {r == '0, r[31], ov};
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check(x.req, "val_e", val_e, x.e);
                check(x.req, "cnd", {31'd0, cnd}, {31'd0, x.c});
                check(x.req, "next_pc", next_pc, x.npc);
                check(x.req, "flags", {29'd0, flags_q}, {29'd0, x.fl});
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R9", "reset flags", {29'd0, flags_q}, 32'd0);
        // R2: 21 - 9 = 12, all flags clear; then R6 equal-jump not taken
        issue("R2", 4'd6, 4'd1, 32'd9, 32'd21, 1'b1);
        issue("R6", 4'd7, 4'd3, 32'd0, 32'd0, 1'b0);
        issue("R7", 4'd7, 4'd0, 32'd0, 32'd0, 1'b0);
        // R1: add with signed overflow, then wrap to zero
        issue("R1", 4'd6, 4'd0, 32'd1, 32'h7fff_ffff, 1'b1);
        for (int f = 0; f < 16; f++) issue("R6", 4'd7, f[3:0], 32'd0, 32'd0, 1'b0);
        issue("R1", 4'd6, 4'd0, 32'd1, 32'hffff_ffff, 1'b1);
        for (int f = 0; f < 8; f++) issue("R6", 4'd7, f[3:0], 32'd0, 32'd0, 1'b0);
        // R4: subtract giving negative without overflow; subtract overflow
        issue("R4", 4'd6, 4'd1, 32'd5, 32'd3, 1'b1);
        for (int f = 0; f < 8; f++) issue("R6", 4'd7, f[3:0], 32'd0, 32'd0, 1'b0);
        issue("R4", 4'd6, 4'd1, 32'd1, 32'h8000_0000, 1'b1);
        for (int f = 0; f < 8; f++) issue("R6", 4'd7, f[3:0], 32'd0, 32'd0, 1'b0);
        // R3: logic ops clear overflow
        issue("R3", 4'd6, 4'd2, 32'hf0f0_1234, 32'h8f0f_ffff, 1'b1);
        issue("R3", 4'd6, 4'd3, 32'hdead_beef, 32'hdead_beef, 1'b1);
        issue("R3", 4'd6, 4'd3, 32'h8000_0001, 32'h0000_0001, 1'b1);
        issue("R5", 4'd7, 4'd1, 32'd0, 32'd0, 1'b0);
        // R5: disabled writes and other classes leave flags alone
        issue("R5", 4'd6, 4'd1, 32'd4, 32'd4, 1'b0);
        issue("R5", 4'd7, 4'd3, 32'd0, 32'd0, 1'b0);
        // R11 / R8: other class codes add and fall through
        issue("R11", 4'd5, 4'd1, 32'd8, 32'h0000_0078, 1'b1);
        issue("R8", 4'd8, 4'd0, 32'd2, 32'd3, 1'b1);
        issue("R8", 4'd7, 4'd3, 32'd0, 32'd0, 1'b0);
        // R10: undefined function for integer op
        issue("R10", 4'd6, 4'd5, 32'd7, 32'd7, 1'b1);
        issue("R10", 4'd6, 4'd15, 32'd1, 32'd0, 1'b1);
        issue("R10", 4'd7, 4'd4, 32'd0, 32'd0, 1'b0);
        // R9: reset mid-run clears flags
        issue("R9", 4'd6, 4'd1, 32'd1, 32'd1, 1'b1);
        @(negedge clk);
        icode = 4'd0; set_cc_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R9", "flags after reset", {29'd0, flags_q}, 32'd0);
        model_fl = 3'b000;
        issue("R9", 4'd7, 4'd4, 32'd0, 32'd0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule